// File: doc/BRIEF.md
# NAND Page ECC Parity Generator

This block watches the byte stream passing through a NAND flash data port and builds a single-error-correcting Hamming code over it. Each 256-byte chunk gets 16 line-parity bits, which locate the byte, and 6 column-parity bits, which locate the bit inside that byte. Together they form a 3-byte code. With the default two chunks, a 512-byte page yields 6 code bytes. Software compares a stored code with a freshly computed one and corrects any single flipped bit itself.

A 2-bit mode input sets what the block does. One mode clears all parity state. One mode folds every strobed data byte into the parity of the current chunk. A third mode turns the block into a byte source: each pop strobe steps a pointer through the code bytes in a fixed order. The fourth mode is off and holds everything. To arm the block, software uses clear, then off, then accumulate. To fetch the code, it uses off, then readout, then one pop per byte, then off again.

Top module: `ecc_page_parity`

## Requirements
- R1: `mode_i` is decoded as 2'b00 off, 2'b01 accumulate, 2'b10 readout, 2'b11 clear. Only the action of the current mode takes effect in a cycle, even if byte and pop strobes arrive together.
- R2: A byte accepted at chunk offset j (0..255) adds its bitwise XOR to line-parity bit LP(2k+1) when bit k of j is 1, and to LP(2k) when bit k of j is 0, for k = 0..7.
- R3: The column parity is taken from the XOR of all accepted bytes in the chunk. CP0 covers data bits 0,2,4,6; CP1 covers bits 1,3,5,7; CP2 covers bits 0,1,4,5; CP3 covers bits 2,3,6,7; CP4 covers bits 0..3; CP5 covers bits 4..7.
- R4: Every parity bit is presented inverted. Code byte A is {LP7..LP0}. Code byte B is {LP15..LP8}. Code byte C is {CP5..CP0, 1, 1}, so its bits 1:0 always read 1.
- R5: `ecc_o` shows the byte at the readout pointer. The order is chunk 0 first: B, A, C, then the same three bytes for chunk 1. A pop in readout mode advances the pointer at that clock edge, so the next byte appears in the same cycle after that edge.
- R6: Bytes 0..255 go to chunk 0 and bytes 256..511 go to chunk 1. Bytes beyond 512 are dropped until the next clear.
- R7: Clear empties both parity sets, the byte count and the pointer, so all six code bytes then read 0xFF. Clear also overrides strobes in the same cycle.
- R8: In off mode, strobed bytes do not change the parity. Pops outside readout mode do not move the pointer.
- R9: When the pointer is past the sixth byte, `ecc_o` reads 0xFF and further pops have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Mode: off, accumulate, readout, clear |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte on the flash port |
| pop_i | input | 1 | Readout pop strobe |
| ecc_o | output | 8 | Code byte at the readout pointer |

## Verification
The byte strobe and the pop strobe can be high in the same cycle. The mode must then choose which one acts. The bench drives pops along with data in accumulate mode, data along with pops in readout mode, and both strobes under clear and off. Its behavioural model accepts exactly one action per cycle, and the output is compared against that model on every clock. A stray pop would shift the readout order, and a stray byte would change a code byte, so either mistake shows up as a mismatch.

// File: rtl/ecc_gen_pkg.sv
package ecc_gen_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ACC  = 2'b01,
    MODE_READ = 2'b10,
    MODE_CLR  = 2'b11
  } ecc_mode_e;

  localparam int CHUNK_BYTES  = 256;
  localparam int ADDR_W       = 8;
  localparam int LP_W         = 2 * ADDR_W;
  localparam int SLOTS_PER_CH = 3;

  // Fold the chunk's running byte XOR into the six column parities.
  function automatic logic [5:0] col_to_cp(input logic [7:0] c);
    logic [5:0] cp;
    cp[0] = ^(c & 8'h55);
    cp[1] = ^(c & 8'hAA);
    cp[2] = ^(c & 8'h33);
    cp[3] = ^(c & 8'hCC);
    cp[4] = ^(c & 8'h0F);
    cp[5] = ^(c & 8'hF0);
    return cp;
  endfunction

endpackage

// File: rtl/ecc_chunk_acc.sv
module ecc_chunk_acc
  import ecc_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        dat_i,
  output logic [LP_W-1:0]   lp_o,
  output logic [7:0]        col_o
);

  logic [LP_W-1:0] lp_q, lp_d;
  logic [7:0]      col_q, col_d;
  logic            row_par;

  always_comb begin
    lp_d    = lp_q;
    col_d   = col_q;
    row_par = ^dat_i;
    if (clr_i) begin
      lp_d  = '0;
      col_d = '0;
    end else if (en_i) begin
      col_d = col_q ^ dat_i;
      for (int k = 0; k < ADDR_W; k++) begin
        if (addr_i[k]) lp_d[2*k+1] = lp_q[2*k+1] ^ row_par;
        else           lp_d[2*k]   = lp_q[2*k]   ^ row_par;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q  <= '0;
      col_q <= '0;
    end else if (clr_i || en_i) begin
      lp_q  <= lp_d;
      col_q <= col_d;
    end
  end

  assign lp_o  = lp_q;
  assign col_o = col_q;

endmodule

// File: rtl/ecc_readout.sv
module ecc_readout
  import ecc_gen_pkg::*;
#(
  parameter int NUM_CHUNKS = 2,
  localparam int NSLOT = SLOTS_PER_CH * NUM_CHUNKS,
  localparam int PTR_W = $clog2(NSLOT + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       pop_i,
  input  logic [NUM_CHUNKS*LP_W-1:0] lp_i,
  input  logic [NUM_CHUNKS*8-1:0]    col_i,
  output logic [PTR_W-1:0]           ptr_o,
  output logic [7:0]                 byte_o
);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             step;

  assign step = pop_i && (ptr_q != PTR_W'(NSLOT));

  always_comb begin
    ptr_d = ptr_q;
    if (clr_i)     ptr_d = '0;
    else if (step) ptr_d = ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ptr_q <= '0;
    else if (clr_i || step) ptr_q <= ptr_d;
  end

  always_comb begin
    byte_o = 8'hFF;
    for (int c = 0; c < NUM_CHUNKS; c++) begin
      if (ptr_q == PTR_W'(SLOTS_PER_CH*c))
        byte_o = ~lp_i[c*LP_W+8 +: 8];
      else if (ptr_q == PTR_W'(SLOTS_PER_CH*c+1))
        byte_o = ~lp_i[c*LP_W +: 8];
      else if (ptr_q == PTR_W'(SLOTS_PER_CH*c+2))
        byte_o = {~col_to_cp(col_i[c*8 +: 8]), 2'b11};
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/ecc_page_parity.sv
module ecc_page_parity
  import ecc_gen_pkg::*;
#(
  parameter int NUM_CHUNKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       pop_i,
  output logic [7:0] ecc_o
);

  localparam int TOTAL = CHUNK_BYTES * NUM_CHUNKS;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam int IDX_W = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1;
  localparam int PTR_W = $clog2(SLOTS_PER_CH * NUM_CHUNKS + 1);

  ecc_mode_e                 mode;
  logic                      clr, take, rd_pop;
  logic [CNT_W-1:0]          cnt_q, cnt_d;
  logic [IDX_W-1:0]          chunk_idx;
  logic [NUM_CHUNKS*LP_W-1:0] lp_all;
  logic [NUM_CHUNKS*8-1:0]   col_all;
  logic [PTR_W-1:0]          rd_ptr;

  assign mode      = ecc_mode_e'(mode_i);
  assign clr       = (mode == MODE_CLR);
  assign take      = (mode == MODE_ACC) && byte_vld_i && (cnt_q < CNT_W'(TOTAL));
  assign rd_pop    = (mode == MODE_READ) && pop_i;
  assign chunk_idx = cnt_q[ADDR_W +: IDX_W];

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (take) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (clr || take) cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_chunk
    ecc_chunk_acc u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr),
      .en_i   (take && (chunk_idx == IDX_W'(g))),
      .addr_i (cnt_q[ADDR_W-1:0]),
      .dat_i  (byte_i),
      .lp_o   (lp_all[g*LP_W +: LP_W]),
      .col_o  (col_all[g*8 +: 8])
    );
  end

  ecc_readout #(.NUM_CHUNKS(NUM_CHUNKS)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .pop_i  (rd_pop),
    .lp_i   (lp_all),
    .col_i  (col_all),
    .ptr_o  (rd_ptr),
    .byte_o (ecc_o)
  );

endmodule

// File: rtl/ecc_page_parity_chk.sv
module ecc_page_parity_chk
  import ecc_gen_pkg::*;
#(
  parameter int NUM_CHUNKS = 2,
  localparam int TOTAL = CHUNK_BYTES * NUM_CHUNKS,
  localparam int CNT_W = $clog2(TOTAL + 1),
  localparam int NSLOT = SLOTS_PER_CH * NUM_CHUNKS,
  localparam int PTR_W = $clog2(NSLOT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             byte_vld_i,
  input logic             pop_i,
  input logic [7:0]       ecc_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [PTR_W-1:0] rd_ptr
);

  // R7
  clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == 2'b11 |=> (cnt_q == '0) && (rd_ptr == '0));

  // R8
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == 2'b00 |=> $stable(cnt_q) && $stable(ecc_o));

  // R8
  pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && (mode_i == 2'b00 || mode_i == 2'b01)) |=> $stable(rd_ptr));

  // R1
  read_no_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && byte_vld_i) |=> $stable(cnt_q));

  // R5
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && pop_i && rd_ptr < PTR_W'(NSLOT)) |=> rd_ptr == $past(rd_ptr) + PTR_W'(1));

  // R9
  past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr >= PTR_W'(NSLOT) |-> ecc_o == 8'hFF);

  // R6
  byte_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(TOTAL));

  // R4
  c_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr < PTR_W'(NSLOT) && (rd_ptr % PTR_W'(3)) == PTR_W'(2)) |-> ecc_o[1:0] == 2'b11);

endmodule

bind ecc_page_parity ecc_page_parity_chk #(.NUM_CHUNKS(NUM_CHUNKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_i     (mode_i),
  .byte_vld_i (byte_vld_i),
  .pop_i      (pop_i),
  .ecc_o      (ecc_o),
  .cnt_q      (cnt_q),
  .rd_ptr     (rd_ptr)
);

// File: tb/sim_ecc_page_parity.sv
`timescale 1ns/1ps
module sim_ecc_page_parity;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       vld;
  logic [7:0] dat;
  logic       pop;
  logic [7:0] ecc_o;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 0;
  string cur_req = "R7";

  logic [7:0] mem [512];
  int m_n   = 0;
  int m_ptr = 0;

  always #5 clk = ~clk;

  ecc_page_parity u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .byte_vld_i(vld),
    .byte_i(dat), .pop_i(pop), .ecc_o(ecc_o)
  );

  function automatic logic [7:0] exp_byte(int p);
    logic [15:0] lp;
    logic [7:0]  col;
    logic [5:0]  cp;
    int c, s;
    if (p >= 6) return 8'hFF;
    c = p / 3; s = p % 3;
    lp = '0; col = '0; cp = '0;
    for (int j = 0; j < 256; j++) begin
      if (c*256 + j < m_n) begin
        col = col ^ mem[c*256+j];
        for (int k = 0; k < 8; k++) begin
          if (((j >> k) & 1) == 1) lp[2*k+1] = lp[2*k+1] ^ (^mem[c*256+j]);
          else                     lp[2*k]   = lp[2*k]   ^ (^mem[c*256+j]);
        end
      end
    end
    for (int b = 0; b < 8; b++)
      for (int q = 0; q < 3; q++)
        if (((b >> q) & 1) == 1) cp[2*q+1] = cp[2*q+1] ^ col[b];
        else                     cp[2*q]   = cp[2*q]   ^ col[b];
    if (s == 0) return ~lp[15:8];
    if (s == 1) return ~lp[7:0];
    return {~cp, 2'b11};
  endfunction

  // behavioural reference, one action per cycle chosen by the mode
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_n = 0; m_ptr = 0;
    end else begin
      case (mode)
        2'b11: begin m_n = 0; m_ptr = 0; end
        2'b01: if (vld && m_n < 512) begin mem[m_n] = dat; m_n = m_n + 1; end
        2'b10: if (pop && m_ptr < 6) m_ptr = m_ptr + 1;
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] e;
      e = exp_byte(m_ptr);
      tests++;
      if (ecc_o !== e) begin
        fails++;
        $display("FAIL %s cycle %0d: ecc_o=%02h expected %02h", cur_req, cyc, ecc_o, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run hung, got cycle %0d expected under 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(input logic [1:0] m, input logic v, input logic [7:0] d, input logic p);
    mode = m; vld = v; dat = d; pop = p;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic read_all(input string req);
    step(2'b00, 0, 8'h00, 0);
    step(2'b10, 0, 8'h00, 0);
    for (int i = 0; i < 8; i++) begin
      chk(req, ecc_o, exp_byte(m_ptr));
      step(2'b10, 1'b1, 8'($urandom), 1'b1);
    end
    chk("R9", ecc_o, 8'hFF);
  endtask

  initial begin
    rst_n = 0; mode = 2'b00; vld = 0; dat = 0; pop = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cur_req = "R7";
    chk("R7", ecc_o, 8'hFF);

    // R2 R3 R4: single set bit, data bit 3 at offset 0xA5
    cur_req = "R2";
    step(2'b11, 0, 0, 0); step(2'b00, 0, 0, 0); step(2'b01, 0, 0, 0);
    for (int i = 0; i < 256; i++) step(2'b01, 1, (i == 165) ? 8'h08 : 8'h00, 0);
    step(2'b00, 0, 0, 0); step(2'b10, 0, 0, 0);
    chk("R2", ecc_o, 8'h66);
    step(2'b10, 0, 0, 1); chk("R2", ecc_o, 8'h99);
    step(2'b10, 0, 0, 1); chk("R3", ecc_o, 8'h97);
    chk("R4", {6'b0, ecc_o[1:0]}, 8'h03);
    step(2'b10, 0, 0, 1); chk("R5", ecc_o, 8'hFF);
    step(2'b10, 0, 0, 1); step(2'b10, 0, 0, 1); step(2'b10, 0, 0, 1);
    chk("R9", ecc_o, 8'hFF);
    step(2'b10, 0, 0, 1); chk("R9", ecc_o, 8'hFF);

    // R6 R8 R1: over-long stream with strobes mixed across modes
    cur_req = "R6";
    step(2'b11, 1, 8'h5A, 1); step(2'b00, 0, 0, 0); step(2'b01, 0, 0, 0);
    for (int i = 0; i < 600; i++) begin
      step(2'b01, 1, 8'($urandom), (i % 5) == 0);
      if (i % 50 == 7) step(2'b00, 1, 8'($urandom), 1);
      if (i % 70 == 9) step(2'b10, 1, 8'($urandom), 0);
    end
    chk("R6", 8'(m_n / 4), 8'(512 / 4));
    cur_req = "R5";
    read_all("R5");

    // R8: bytes in off mode leave the code unchanged
    cur_req = "R8";
    step(2'b11, 0, 0, 0); step(2'b01, 0, 0, 0);
    for (int i = 0; i < 300; i++) step(2'b01, 1, 8'(i*7+3), 0);
    for (int i = 0; i < 20; i++) step(2'b00, 1, 8'($urandom), 1);
    read_all("R8");

    // R7: clear mid-stream with strobes in the same cycle wins
    cur_req = "R7";
    step(2'b11, 0, 0, 0); step(2'b01, 0, 0, 0);
    for (int i = 0; i < 40; i++) step(2'b01, 1, 8'($urandom), 0);
    step(2'b11, 1, 8'hC3, 1);
    step(2'b00, 0, 0, 0); step(2'b10, 0, 0, 0);
    for (int i = 0; i < 6; i++) begin
      chk("R7", ecc_o, 8'hFF);
      step(2'b10, 0, 0, 1);
    end

    // R1: full two-chunk page of random data
    cur_req = "R1";
    step(2'b11, 0, 0, 0); step(2'b00, 0, 0, 0); step(2'b01, 0, 0, 0);
    for (int i = 0; i < 512; i++) step(2'b01, 1, 8'($urandom), 1);
    read_all("R1");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule